// File: doc/BRIEF.md
# Multi-format stereo serial audio port

This block moves stereo audio between parallel sample registers and a four-wire serial link: a bit clock, a left/right clock, one transmit line and one receive line. Each frame is 64 bit clocks long. The left/right clock is low for the 32 left bit slots and high for the 32 right bit slots. A two-bit format input picks where each sample sits inside its half-frame. In left-justified format the MSB sits in the first slot. In standard I2S format it sits one slot later. In right-justified format the LSB sits in the last slot, so the MSB comes W slots before the next left/right clock edge. Slots that no sample bit occupies carry zero.

A mode input makes the port the clock master or a follower. As master it divides the system clock to make the bit clock and derives the left/right clock from its own slot counter. As follower it synchronises the external bit clock and left/right clock into the system clock domain. It then realigns its slot counter at every left/right clock transition, and it holds its own clock outputs low. Samples to send enter through a valid/ready handshake into a one-pair holding register. Each received left/right pair is returned with a one-cycle valid pulse. Configuration inputs are meant to change only while reset is asserted.

Top module: `i2s_port`

## Requirements
- R1: In master mode the bit clock output toggles every DIV system clocks. The left/right clock output changes only together with a falling bit clock edge, is low for 32 bit clocks and high for 32, and a frame is 64 bit clocks.
- R2: The transmit line changes only on falling bit clock edges, and receive data is sampled on rising bit clock edges.
- R3: With fmtSel = 1 (and also 3), the MSB of each channel is sent in the first bit slot after the left/right clock transition, followed by the lower bits in descending order.
- R4: With fmtSel = 0, the MSB of each channel is sent in the second bit slot after the transition, one bit clock later than in R3.
- R5: With fmtSel = 2, the LSB of each channel is sent in the last slot before the next transition, so the MSB comes W bit clocks before that transition.
- R6: Every bit slot that holds no sample bit is driven as zero.
- R7: txReady is high exactly when the one-pair holding register is empty, and a transfer happens when txValid and txReady are both high at a clock edge. The waiting pair moves into the shifter at the falling edge that starts slot 63. That is the last right slot, so the pair is sent in the frame that starts on the next falling edge. The right sample is held back until slot 31 begins.
- R8: If no pair is waiting when slot 63 begins, the following frame sends zero on both channels.
- R9: When the last bit of a right channel has been received, rxValid pulses for one cycle. rxLeft and rxRight then hold the left and right samples of that frame, and no capture takes place before the first falling bit clock edge after reset.
- R10: With isMaster low, the port times itself from bclkIn and lrclkIn. A low-to-high left/right clock change starts slot 32 and a high-to-low change starts slot 0, and bclkOut and lrclkOut stay low.
- R11: During reset sdOut, bclkOut and rxValid are low, txReady is high, and lrclkOut equals isMaster (master idles in the right slot).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| fmtSel | input | 2 | Framing: 0 standard I2S, 1 left-justified, 2 right-justified, 3 as 1 |
| isMaster | input | 1 | 1: generate bit and left/right clocks; 0: follow external ones |
| bclkIn | input | 1 | External bit clock (follower mode) |
| lrclkIn | input | 1 | External left/right clock (follower mode) |
| sdIn | input | 1 | Serial receive data |
| bclkOut | output | 1 | Generated bit clock (low in follower mode) |
| lrclkOut | output | 1 | Generated left/right clock (low in follower mode) |
| sdOut | output | 1 | Serial transmit data |
| txLeft | input | W | Left sample to send |
| txRight | input | W | Right sample to send |
| txValid | input | 1 | Sample pair offered |
| txReady | output | 1 | Holding register empty |
| rxLeft | output | W | Last received left sample |
| rxRight | output | W | Last received right sample |
| rxValid | output | 1 | One-cycle pulse: new received pair |

## Verification
In master mode, sdOut and lrclkOut change at the same system clock edge as bclkOut falls. The bench therefore updates its expected line values when it sees that fall and compares them at every falling system clock edge. In follower mode the outputs move three system clocks after the external bit clock falls, two for the synchroniser and one for the register. The bench then compares sdOut only at its own rising bit clock edges, four cycles after the fall. rxValid arrives in the cycle that follows the rising edge carrying a right-channel LSB; in follower mode that edge is delayed by the same three-cycle synchroniser path. The bench matches each pulse against a queue of pairs that its model commits at slot 31. txReady is checked every cycle in master mode, because there the bench's model of the latch timing is exact to the cycle.

// File: rtl/i2s_pkg.sv
package i2s_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_RJ   = 2'd2,
    FMT_RSVD = 2'd3
  } fmt_e;

  // strobes from the timing control to the datapath
  typedef struct packed {
    logic       fall;
    logic       rise;
    logic       synced;
    logic [5:0] slot;
    logic [5:0] slotNext;
  } strobes_t;

endpackage

// File: rtl/i2s_ctrl.sv
module i2s_ctrl
  import i2s_pkg::*;
#(
  parameter int DIV = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     isMaster,
  input  logic     bclkIn,
  input  logic     lrclkIn,
  output logic     bclkOut,
  output logic     lrclkOut,
  output strobes_t strb
);

  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

  logic [DW-1:0] divCnt;
  logic          bclkGen;
  logic [2:0]    bSync;
  logic [1:0]    lSync;
  logic          lrPrev;
  logic [5:0]    slot;
  logic [5:0]    slotNext;
  logic          synced;
  logic          genToggle;
  logic          fallTick;
  logic          riseTick;
  logic          lrSeen;

  // master bit clock divider
  always_ff @(posedge clk) begin
    if (!rstN || !isMaster) begin
      divCnt  <= '0;
      bclkGen <= 1'b0;
    end else if (divCnt == DIV_LAST) begin
      divCnt  <= '0;
      bclkGen <= ~bclkGen;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // follower synchronisers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSync <= '0;
      lSync <= '0;
    end else begin
      bSync <= {bSync[1:0], bclkIn};
      lSync <= {lSync[0], lrclkIn};
    end
  end

  assign genToggle = isMaster && (divCnt == DIV_LAST);
  assign lrSeen    = lSync[1];

  always_comb begin
    if (isMaster) begin
      fallTick = genToggle && bclkGen;
      riseTick = genToggle && !bclkGen;
    end else begin
      fallTick = bSync[2] && !bSync[1];
      riseTick = !bSync[2] && bSync[1];
    end
    if (!isMaster && (lrSeen != lrPrev)) slotNext = {lrSeen, 5'd0};
    else                                 slotNext = slot + 6'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slot   <= 6'd63;
      lrPrev <= 1'b1;
      synced <= 1'b0;
    end else if (fallTick) begin
      slot   <= slotNext;
      lrPrev <= lrSeen;
      synced <= 1'b1;
    end
  end

  assign bclkOut  = isMaster && bclkGen;
  assign lrclkOut = isMaster && slot[5];

  always_comb begin
    strb.fall     = fallTick;
    strb.rise     = riseTick;
    strb.synced   = synced;
    strb.slot     = slot;
    strb.slotNext = slotNext;
  end

  // R1
  lr_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lrclkOut) |-> $fell(bclkOut));

endmodule

// File: rtl/i2s_dp.sv
module i2s_dp
  import i2s_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rstN,
  input  fmt_e         fmt,
  input  strobes_t     strb,
  input  logic [W-1:0] txLeft,
  input  logic [W-1:0] txRight,
  input  logic         txValid,
  output logic         txReady,
  output logic         sdOut,
  input  logic         sdIn,
  output logic [W-1:0] rxLeft,
  output logic [W-1:0] rxRight,
  output logic         rxValid
);

  localparam logic [6:0] RJ_SHIFT = 7'(32 - W);
  localparam logic [6:0] TOP_IDX  = 7'(W - 1);
  localparam logic [6:0] WIDTH7   = 7'(W);

  typedef struct packed {
    logic       hit;
    logic       chan;
    logic [4:0] idx;
  } bitPos_t;

  // slot number -> channel and sample bit index for the selected framing
  function automatic bitPos_t mapSlot(input fmt_e f, input logic [5:0] s);
    bitPos_t    r;
    logic [5:0] q;
    logic [6:0] k;
    q      = (f == FMT_I2S) ? s - 6'd1 : s;
    k      = {2'b00, q[4:0]} - ((f == FMT_RJ) ? RJ_SHIFT : 7'd0);
    r.hit  = !k[6] && (k < WIDTH7);
    r.chan = q[5];
    r.idx  = 5'(TOP_IDX - k);
    return r;
  endfunction

  logic [W-1:0] holdL, holdR, actL, actR, pendR;
  logic [W-1:0] shL, shR;
  logic         holdFull;
  logic         latchPair;
  bitPos_t      txPos, rxPos;

  assign txPos     = mapSlot(fmt, strb.slotNext);
  assign rxPos     = mapSlot(fmt, strb.slot);
  assign latchPair = strb.fall && (strb.slotNext == 6'd63);
  assign txReady   = !holdFull;

  // transmit side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdL <= '0; holdR <= '0; holdFull <= 1'b0;
      actL <= '0; actR <= '0; pendR <= '0;
      sdOut <= 1'b0;
    end else begin
      if (strb.fall) begin
        sdOut <= txPos.hit ? (txPos.chan ? actR[txPos.idx] : actL[txPos.idx]) : 1'b0;
        if (strb.slotNext == 6'd31) actR <= pendR;
      end
      if (latchPair) begin
        actL     <= holdFull ? holdL : '0;
        pendR    <= holdFull ? holdR : '0;
        holdFull <= 1'b0;
      end
      if (txValid && !holdFull) begin
        holdL    <= txLeft;
        holdR    <= txRight;
        holdFull <= 1'b1;
      end
    end
  end

  // receive side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shL <= '0; shR <= '0;
      rxLeft <= '0; rxRight <= '0; rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strb.rise && strb.synced && rxPos.hit) begin
        if (rxPos.chan) shR[rxPos.idx] <= sdIn;
        else            shL[rxPos.idx] <= sdIn;
        if (rxPos.chan && rxPos.idx == 5'd0) begin
          rxLeft  <= shL;
          rxRight <= {shR[W-1:1], sdIn};
          rxValid <= 1'b1;
        end
      end
    end
  end

  // R2
  sd_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdOut) |-> $past(strb.fall));

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady |=> !txReady);

  // R9
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

endmodule

// File: rtl/i2s_port.sv
module i2s_port
  import i2s_pkg::*;
#(
  parameter int W   = 24,
  parameter int DIV = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   fmtSel,
  input  logic         isMaster,
  input  logic         bclkIn,
  input  logic         lrclkIn,
  input  logic         sdIn,
  output logic         bclkOut,
  output logic         lrclkOut,
  output logic         sdOut,
  input  logic [W-1:0] txLeft,
  input  logic [W-1:0] txRight,
  input  logic         txValid,
  output logic         txReady,
  output logic [W-1:0] rxLeft,
  output logic [W-1:0] rxRight,
  output logic         rxValid
);

  fmt_e     fmt;
  strobes_t strb;

  assign fmt = fmt_e'(fmtSel);

  i2s_ctrl #(.DIV(DIV)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .isMaster (isMaster),
    .bclkIn   (bclkIn),
    .lrclkIn  (lrclkIn),
    .bclkOut  (bclkOut),
    .lrclkOut (lrclkOut),
    .strb     (strb)
  );

  i2s_dp #(.W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .fmt     (fmt),
    .strb    (strb),
    .txLeft  (txLeft),
    .txRight (txRight),
    .txValid (txValid),
    .txReady (txReady),
    .sdOut   (sdOut),
    .sdIn    (sdIn),
    .rxLeft  (rxLeft),
    .rxRight (rxRight),
    .rxValid (rxValid)
  );

endmodule

// File: tb/test_i2s_port.sv
module test_i2s_port;

  localparam int W    = 24;
  localparam int DIV  = 2;
  localparam int HALF = 4;

  logic         clk = 1'b0;
  logic         rstN;
  logic [1:0]   fmtSel;
  logic         isMaster;
  logic         bclkIn, lrclkIn;
  logic         sdIn;
  logic         bclkOut, lrclkOut, sdOut;
  logic [W-1:0] txLeft, txRight, rxLeft, rxRight;
  logic         txValid, txReady, rxValid;

  assign sdIn = sdOut;  // loopback

  i2s_port #(.W(W), .DIV(DIV)) i_i2s_port (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .isMaster(isMaster),
    .bclkIn(bclkIn), .lrclkIn(lrclkIn), .sdIn(sdIn),
    .bclkOut(bclkOut), .lrclkOut(lrclkOut), .sdOut(sdOut),
    .txLeft(txLeft), .txRight(txRight), .txValid(txValid), .txReady(txReady),
    .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid)
  );

  always #2ns clk = ~clk;

  int compared = 0;
  int mismatched = 0;

  // behavioural model state
  int           mp;
  logic [W-1:0] mActL, mActR, mPendR, mHoldL, mHoldR;
  bit           mHoldFull;
  logic         expBit, expLr;
  logic [2*W-1:0] expQ[$];
  int  seq = 0;
  bit  acceptPend, txEnable, prevBclk, firstEdge;
  int  sinceEdge, sc, rxSeen;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] patL(input int s);
    logic [31:0] v;
    v = 32'(s) * 32'h9E37_79B1 ^ 32'h0F0F_5A5A;
    return v[W-1:0];
  endfunction

  function automatic logic [W-1:0] patR(input int s);
    logic [31:0] v;
    v = 32'(s) * 32'h85EB_CA6B + 32'h1234_5678;
    return v[W-1:0];
  endfunction

  // first slot of the MSB inside a half-frame
  function automatic int firstSlot();
    case (fmtSel)
      2'd0:    return 1;
      2'd2:    return 32 - W;
      default: return 0;
    endcase
  endfunction

  function automatic int offsetIn(input int p, input int c);
    return (p - (c * 32 + firstSlot()) + 64) % 64;
  endfunction

  function automatic bit slotUsed(input int p);
    return (offsetIn(p, 0) < W) || (offsetIn(p, 1) < W);
  endfunction

  function automatic logic expBitAt(input int p);
    if (offsetIn(p, 0) < W) return mActL[W-1-offsetIn(p, 0)];
    if (offsetIn(p, 1) < W) return mActR[W-1-offsetIn(p, 1)];
    return 1'b0;
  endfunction

  function automatic string dataTag(input int p);
    if (!slotUsed(p)) return "R6 unused slot zero";
    case (fmtSel)
      2'd0:    return "R4 standard framing bit";
      2'd2:    return "R5 right-justified bit";
      default: return "R3 left-justified bit";
    endcase
  endfunction

  task automatic modelFall();
    mp = (mp + 1) % 64;
    if (mp == 63) begin
      mActL     = mHoldFull ? mHoldL : '0;
      mPendR    = mHoldFull ? mHoldR : '0;
      mHoldFull = 1'b0;
    end
    if (mp == 31) begin
      mActR = mPendR;
      expQ.push_back({mActL, mActR});
    end
    expBit = expBitAt(mp);
    expLr  = (mp >= 32);
  endtask

  task automatic step();
    logic [2*W-1:0] e;
    @(negedge clk);
    if (isMaster) begin
      sinceEdge++;
      if (bclkOut !== prevBclk) begin
        if (!firstEdge) check(sinceEdge == DIV, "R1 bit clock half period", 64'(sinceEdge), 64'(DIV));
        firstEdge = 1'b0;
        sinceEdge = 0;
        if (prevBclk) modelFall();
        prevBclk = bclkOut;
      end
      check(sdOut === expBit, dataTag(mp), 64'(sdOut), 64'(expBit));
      check(lrclkOut === expLr, "R1 left/right clock", 64'(lrclkOut), 64'(expLr));
    end else begin
      check(bclkOut === 1'b0 && lrclkOut === 1'b0, "R10 clock outputs low",
            64'({bclkOut, lrclkOut}), 64'(0));
      sc++;
      if (sc == HALF) begin
        sc = 0;
        if (bclkIn) begin
          bclkIn = 1'b0;
          modelFall();
          lrclkIn = (mp >= 32);
        end else begin
          bclkIn = 1'b1;
          check(sdOut === expBit, {"R10 ", dataTag(mp)}, 64'(sdOut), 64'(expBit));
        end
      end
    end
    if (acceptPend) begin
      mHoldL = patL(seq);
      mHoldR = patR(seq);
      mHoldFull = 1'b1;
      seq++;
    end
    if (isMaster) check(txReady === !mHoldFull, "R7 ready tracks holding register",
                        64'(txReady), 64'(!mHoldFull));
    if (rxValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 unexpected receive pulse", 64'(1), 64'(0));
      end else begin
        e = expQ.pop_front();
        check({rxLeft, rxRight} === e, (e == '0) ? "R8 underrun pair zero" : "R9 received pair",
              64'({rxLeft, rxRight}), 64'(e));
        rxSeen++;
      end
    end
    txValid    = txEnable;
    txLeft     = patL(seq);
    txRight    = patR(seq);
    acceptPend = txEnable && txReady;
  endtask

  task automatic runTest(input logic [1:0] f, input bit m, input int cycles,
                         input int gapLo, input int gapHi);
    rstN = 1'b0; fmtSel = f; isMaster = m;
    txValid = 1'b0; txLeft = '0; txRight = '0;
    bclkIn = 1'b0; lrclkIn = 1'b1;
    mp = 63; mActL = '0; mActR = '0; mPendR = '0; mHoldL = '0; mHoldR = '0;
    mHoldFull = 1'b0; expQ.delete(); expBit = 1'b0; expLr = m;
    acceptPend = 1'b0; prevBclk = 1'b0; sinceEdge = 0; firstEdge = 1'b1;
    sc = 0; rxSeen = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(sdOut === 1'b0 && rxValid === 1'b0 && bclkOut === 1'b0, "R11 reset outputs low",
          64'({sdOut, rxValid, bclkOut}), 64'(0));
    check(txReady === 1'b1, "R11 reset ready", 64'(txReady), 64'(1));
    check(lrclkOut === m, "R11 reset left/right clock", 64'(lrclkOut), 64'(m));
    rstN = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      txEnable = !(i >= gapLo && i < gapHi);
      step();
    end
    check(rxSeen >= 3, "R9 pairs received", 64'(rxSeen), 64'(3));
  endtask

  initial begin
    runTest(2'd1, 1'b1, 1800, 300, 900);   // left-justified master with underrun
    runTest(2'd0, 1'b1, 1400, 0, 0);       // standard framing master
    runTest(2'd2, 1'b1, 1400, 0, 0);       // right-justified master
    runTest(2'd3, 1'b1, 1100, 0, 0);       // code 3 behaves as left-justified
    runTest(2'd0, 1'b0, 2600, 0, 0);       // follower, standard framing
    runTest(2'd2, 1'b0, 2600, 0, 0);       // follower, right-justified
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400us;
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule